// File: doc/BRIEF.md
# Status Register Lock Controller

This block guards the protection-configuration bits of a serial flash status register: the block-protect size field, the top/bottom selector, the sector-granularity flag, the complement flag and the pin-enable flag. Each status write request carries new bit values. The block either commits them or refuses them, and it reports the outcome as a one-cycle accept or reject pulse. Command decoding on the serial bus and the timing of non-volatile storage are handled elsewhere. Here the non-volatile bits are ordinary registers. They keep their value through a power-on reset (`rstN`) and clear only when the device is modelled as blank (`blankN`).

Four lock levels can hold the protection bits, and each has its own release condition. A pin-gated lock applies while the pin-enable flag is set and the write-protect pin is low. It releases when the pin goes high. A power-lock is set by a write and clears only at the next power-on reset. A permanent lock is set by a two-byte unlock-code sequence and never releases in the field. With none of these active the register is unlocked. `lockMode` reports the level currently in force. Every write must be preceded by a write-enable, which is consumed by the write attempt.

Top module: `srlock_top`

## Requirements
- R1: After power-on reset (`rstN` low) the write-enable latch, the power-lock flag and both outcome pulses are 0, and status bits 6..0 and the permanent-lock bit keep their values. With `blankN` low every status bit reads 0.
- R2: A `wrenReq` pulse sets the write-enable latch (status bit 9). A write request that arrives while the latch is clear is rejected.
- R3: The latch clears after every write attempt, whether it is accepted or rejected. If `wrenReq` and `wrReq` come in the same cycle, the write is judged on the old latch value and the latch ends set.
- R4: An accepted write copies `wrData[6:0]` into status bits 6..0 (bits 2..0 block-protect size, 3 top/bottom, 4 sector flag, 5 complement, 6 pin-enable) on the next clock and raises `wrAck` for exactly one cycle.
- R5: A rejected write leaves every status bit unchanged and raises `wrRej` for exactly one cycle. `wrAck` and `wrRej` are never high together.
- R6: While status bit 6 is 1 and `wpN` is low, a write whose bits 6..0 differ from the stored ones is rejected. A write of identical bits is accepted. With `wpN` high, or with bit 6 clear, the pin has no effect.
- R7: An accepted write with `wrData[7]`=1 sets the power-lock flag (status bit 7). A later write with bit 7 at 0 does not clear the flag. While the flag is set, changes to bits 6..0 are rejected whatever the pin level. The flag clears only at power-on reset.
- R8: The byte `SEQ_FIRST` (default 8'hA5) followed on the next valid byte by `SEQ_SECOND` (default 8'h5A) sets the permanent-lock bit (status bit 8). From then on, changes to bits 6..0 are rejected. The bit survives power-on reset.
- R9: Any other valid byte between the two code bytes aborts the sequence. A repeated first byte keeps the sequence armed. Cycles with `seqValid` low do not abort it.
- R10: `lockMode` reads 3 when the permanent lock is set, otherwise 2 when the power-lock is set, otherwise 1 when bit 6 is 1 and `wpN` is low, otherwise 0.
- R11: When a write and the completion of the code sequence fall on the same clock edge, the write is judged against the lock state that held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, asynchronous, active low; clears volatile state |
| blankN | input | 1 | Blank-device initialisation, asynchronous, active low; clears non-volatile bits |
| wpN | input | 1 | Write-protect pin level |
| wrenReq | input | 1 | Write-enable command strobe |
| wrReq | input | 1 | Status write request strobe |
| wrData | input | 8 | New protection bits [6:0], power-lock request [7] |
| seqValid | input | 1 | Lock-code byte valid |
| seqByte | input | 8 | Lock-code byte |
| status | output | 10 | {latch, permanent lock, power-lock, protection bits[6:0]} |
| lockMode | output | 2 | Lock level in force (0 none, 1 pin, 2 power, 3 permanent) |
| wrAck | output | 1 | One-cycle write-accepted pulse |
| wrRej | output | 1 | One-cycle write-rejected pulse |

## Verification
Two events can land on the same edge: a status write and the final byte of the permanent-lock code. The bench arms the code with two first bytes and an idle write-enable cycle. It then drives the second code byte together with a write that changes the protection bits. Because the write is judged on the lock state before that edge, it must be accepted, and the permanent-lock bit must rise in the same cycle. A second collision is a write-enable arriving in the same cycle as a write while the latch is clear. The write must be rejected, and the latch must end up set.

// File: rtl/srlock_pkg.sv
package srlock_pkg;

  typedef enum logic [1:0] {
    LK_NONE  = 2'd0,
    LK_PIN   = 2'd1,
    LK_POWER = 2'd2,
    LK_PERM  = 2'd3
  } lockKindE;

  typedef struct packed {
    logic commit;
    logic pslSet;
    logic srlSet;
  } srStrobeT;

endpackage

// File: rtl/srlock_ctrl.sv
module srlock_ctrl
  import srlock_pkg::*;
#(
  parameter int PROT_W = 7,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SEQ_FIRST  = 'hA5,
  parameter logic [BYTE_W-1:0] SEQ_SECOND = 'h5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  logic              wrenReq,
  input  logic              wrReq,
  input  logic [PROT_W:0]   wrData,
  input  logic              seqValid,
  input  logic [BYTE_W-1:0] seqByte,
  input  logic [PROT_W-1:0] protCur,
  input  logic              pslCur,
  input  logic              srlCur,
  output srStrobeT          strobe,
  output logic              wel,
  output logic [1:0]        lockMode,
  output logic              wrAck,
  output logic              wrRej
);

  localparam int SRP_BIT = PROT_W - 1;

  lockKindE mode;
  logic     armed;
  logic     protChange;
  logic     refuse;
  logic     seqFire;

  // Lock level, highest precedence first.
  always_comb begin
    if (srlCur)                         mode = LK_PERM;
    else if (pslCur)                    mode = LK_POWER;
    else if (protCur[SRP_BIT] && !wpN)  mode = LK_PIN;
    else                                mode = LK_NONE;
  end

  assign lockMode   = mode;
  assign protChange = (wrData[PROT_W-1:0] != protCur);
  assign refuse     = !wel || ((mode != LK_NONE) && protChange);
  assign seqFire    = seqValid && armed && (seqByte == SEQ_SECOND);

  always_comb begin
    strobe.commit = wrReq && !refuse;
    strobe.pslSet = wrReq && !refuse && wrData[PROT_W];
    strobe.srlSet = seqFire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel   <= 1'b0;
      armed <= 1'b0;
      wrAck <= 1'b0;
      wrRej <= 1'b0;
    end else begin
      if (wrenReq)      wel <= 1'b1;
      else if (wrReq)   wel <= 1'b0;
      if (seqValid)     armed <= (seqByte == SEQ_FIRST);
      wrAck <= wrReq && !refuse;
      wrRej <= wrReq && refuse;
    end
  end

endmodule

// File: rtl/srlock_dp.sv
module srlock_dp
  import srlock_pkg::*;
#(
  parameter int PROT_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              blankN,
  input  srStrobeT          strobe,
  input  logic [PROT_W-1:0] wrProt,
  output logic [PROT_W-1:0] protQ,
  output logic              pslQ,
  output logic              srlQ
);

  // Non-volatile cells: survive power-on reset, cleared only on blank init.
  always_ff @(posedge clk or negedge blankN) begin
    if (!blankN) begin
      protQ <= '0;
      srlQ  <= 1'b0;
    end else begin
      if (strobe.commit) protQ <= wrProt;
      if (strobe.srlSet) srlQ  <= 1'b1;
    end
  end

  // Volatile power-lock flag: lost on every power-down.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pslQ <= 1'b0;
    else if (strobe.pslSet) pslQ <= 1'b1;
  end

endmodule

// File: rtl/srlock_top.sv
module srlock_top
  import srlock_pkg::*;
#(
  parameter int BP_W   = 3,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SEQ_FIRST  = 'hA5,
  parameter logic [BYTE_W-1:0] SEQ_SECOND = 'h5A,
  localparam int PROT_W = BP_W + 4,
  localparam int DATA_W = PROT_W + 1,
  localparam int ST_W   = PROT_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              blankN,
  input  logic              wpN,
  input  logic              wrenReq,
  input  logic              wrReq,
  input  logic [DATA_W-1:0] wrData,
  input  logic              seqValid,
  input  logic [BYTE_W-1:0] seqByte,
  output logic [ST_W-1:0]   status,
  output logic [1:0]        lockMode,
  output logic              wrAck,
  output logic              wrRej
);

  srStrobeT          strobe;
  logic [PROT_W-1:0] protQ;
  logic              pslQ;
  logic              srlQ;
  logic              wel;

  srlock_ctrl #(
    .PROT_W(PROT_W), .BYTE_W(BYTE_W),
    .SEQ_FIRST(SEQ_FIRST), .SEQ_SECOND(SEQ_SECOND)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wpN(wpN),
    .wrenReq(wrenReq), .wrReq(wrReq), .wrData(wrData),
    .seqValid(seqValid), .seqByte(seqByte),
    .protCur(protQ), .pslCur(pslQ), .srlCur(srlQ),
    .strobe(strobe), .wel(wel), .lockMode(lockMode),
    .wrAck(wrAck), .wrRej(wrRej)
  );

  srlock_dp #(.PROT_W(PROT_W)) u_dp (
    .clk(clk), .rstN(rstN), .blankN(blankN),
    .strobe(strobe), .wrProt(wrData[PROT_W-1:0]),
    .protQ(protQ), .pslQ(pslQ), .srlQ(srlQ)
  );

  assign status = {wel, srlQ, pslQ, protQ};

endmodule

// File: rtl/srlock_chk.sv
module srlock_chk #(
  parameter int BP_W   = 3,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SEQ_SECOND = 'h5A,
  localparam int PROT_W = BP_W + 4,
  localparam int DATA_W = PROT_W + 1,
  localparam int ST_W   = PROT_W + 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              blankN,
  input logic              wpN,
  input logic              wrenReq,
  input logic              wrReq,
  input logic [DATA_W-1:0] wrData,
  input logic              seqValid,
  input logic [BYTE_W-1:0] seqByte,
  input logic [ST_W-1:0]   status,
  input logic [1:0]        lockMode,
  input logic              wrAck,
  input logic              wrRej
);

  localparam int SRP = PROT_W - 1;
  localparam int PSL = PROT_W;
  localparam int SRL = PROT_W + 1;
  localparam int WEL = PROT_W + 2;

  p_need_wel_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !status[WEL] |=> wrRej);

  p_wel_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrenReq |=> !status[WEL]);

  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAck && wrRej));

  p_reject_keeps_r5: assert property (@(posedge clk) disable iff (!rstN || !blankN)
    wrRej |-> $stable(status[PROT_W-1:0]));

  p_pin_block_r6: assert property (@(posedge clk) disable iff (!rstN || !blankN)
    wrReq && status[SRP] && !wpN && (wrData[PROT_W-1:0] != status[PROT_W-1:0]) |=> !wrAck);

  p_psl_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    status[PSL] |=> status[PSL]);

  p_psl_set_r7: assert property (@(posedge clk) disable iff (!rstN || !blankN)
    wrReq && status[WEL] && wrData[PROT_W] && (wrData[PROT_W-1:0] == status[PROT_W-1:0])
    |=> status[PSL]);

  p_perm_sticky_r8: assert property (@(posedge clk) disable iff (!blankN)
    status[SRL] |=> status[SRL]);

  p_srl_only_after_second_r9: assert property (@(posedge clk) disable iff (!blankN || !rstN)
    !status[SRL] && !(seqValid && seqByte == SEQ_SECOND) |=> !status[SRL]);

  p_mode_perm_r10: assert property (@(posedge clk) disable iff (!blankN)
    status[SRL] |-> lockMode == 2'd3);

endmodule

bind srlock_top srlock_chk #(.BP_W(BP_W), .BYTE_W(BYTE_W), .SEQ_SECOND(SEQ_SECOND)) u_chk (
  .clk(clk), .rstN(rstN), .blankN(blankN), .wpN(wpN),
  .wrenReq(wrenReq), .wrReq(wrReq), .wrData(wrData),
  .seqValid(seqValid), .seqByte(seqByte),
  .status(status), .lockMode(lockMode), .wrAck(wrAck), .wrRej(wrRej)
);

// File: tb/sim_srlock_top.sv
module sim_srlock_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       blankN = 1'b0;
  logic       wpN = 1'b1;
  logic       wrenReq = 1'b0;
  logic       wrReq = 1'b0;
  logic [7:0] wrData = '0;
  logic       seqValid = 1'b0;
  logic [7:0] seqByte = '0;
  logic [9:0] status;
  logic [1:0] lockMode;
  logic       wrAck;
  logic       wrRej;

  always #(CLK_PERIOD/2) clk = ~clk;

  srlock_top u0 (
    .clk(clk), .rstN(rstN), .blankN(blankN), .wpN(wpN),
    .wrenReq(wrenReq), .wrReq(wrReq), .wrData(wrData),
    .seqValid(seqValid), .seqByte(seqByte),
    .status(status), .lockMode(lockMode), .wrAck(wrAck), .wrRej(wrRej)
  );

  // Behavioural reference state
  logic [6:0] mProt = '0;
  bit mPsl, mSrl, mWel, mArm, mAck, mRej;
  int nRun = 0;
  int nFail = 0;
  string curReq = "R1";

  function automatic logic [1:0] mMode();
    if (mSrl) return 2'd3;
    if (mPsl) return 2'd2;
    if (mProt[6] && !wpN) return 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp, string what);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic modelEdge();
    logic [1:0] md;
    bit bad, fire;
    if (!blankN) begin mProt = '0; mSrl = 0; end
    if (!rstN) begin
      mWel = 0; mPsl = 0; mArm = 0; mAck = 0; mRej = 0;
      return;
    end
    md   = mMode();
    bad  = !mWel || (md != 2'd0 && wrData[6:0] != mProt);
    fire = seqValid && mArm && seqByte == 8'h5A;
    mAck = 0; mRej = 0;
    if (wrReq) begin
      if (bad) mRej = 1;
      else begin
        mAck = 1;
        mProt = wrData[6:0];
        if (wrData[7]) mPsl = 1;
      end
    end
    if (fire) mSrl = 1;
    if (seqValid) mArm = (seqByte == 8'hA5);
    if (wrenReq) mWel = 1;
    else if (wrReq) mWel = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk(curReq, 32'(status), 32'({mWel, mSrl, mPsl, mProt}), "model status");
    chk(curReq, 32'(wrAck), 32'(mAck), "model wrAck");
    chk(curReq, 32'(wrRej), 32'(mRej), "model wrRej");
    chk(curReq, 32'(lockMode), 32'(mMode()), "model lockMode");
  endtask

  task automatic clearIn();
    wrReq = 0; wrenReq = 0; seqValid = 0;
  endtask

  task automatic doWren();
    wrenReq = 1; tick(); clearIn();
  endtask

  task automatic doWrite(logic [7:0] d);
    wrData = d; wrReq = 1; tick(); clearIn();
  endtask

  task automatic doSeq(logic [7:0] b);
    seqByte = b; seqValid = 1; tick(); clearIn();
  endtask

  task automatic powerCycle();
    rstN = 0; tick(); tick(); rstN = 1; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // R1: blank device plus power-on
    curReq = "R1";
    repeat (3) tick();
    rstN = 1; blankN = 1;
    tick();
    chk("R1", 32'(status), 0, "status after reset");
    chk("R1", 32'(lockMode), 0, "lockMode after reset");

    // R2: write without enable
    curReq = "R2";
    doWrite(8'h05);
    chk("R2", 32'(wrRej), 1, "reject without latch");
    chk("R2", 32'(status[6:0]), 0, "bits unchanged");
    doWren();
    chk("R2", 32'(status[9]), 1, "latch set");

    // R4: accepted write
    curReq = "R4";
    doWrite(8'h05);
    chk("R4", 32'(wrAck), 1, "ack");
    chk("R4", 32'(status[6:0]), 32'h05, "bits written");
    chk("R3", 32'(status[9]), 0, "latch cleared after accept");
    tick();
    chk("R4", 32'(wrAck), 0, "ack one cycle");

    // R6: pin-gated lock
    curReq = "R6";
    doWren(); doWrite(8'h45);
    wpN = 0; tick();
    chk("R10", 32'(lockMode), 1, "pin mode");
    doWren(); doWrite(8'h47);
    chk("R6", 32'(wrRej), 1, "pin blocks change");
    chk("R5", 32'(status[6:0]), 32'h45, "reject keeps bits");
    chk("R3", 32'(status[9]), 0, "latch cleared after reject");
    tick();
    chk("R5", 32'(wrRej), 0, "reject one cycle");
    doWren(); doWrite(8'h45);
    chk("R6", 32'(wrAck), 1, "identical write accepted");
    wpN = 1; doWren(); doWrite(8'h47);
    chk("R6", 32'(wrAck), 1, "pin high allows");
    wpN = 0; doWren(); doWrite(8'h07);
    chk("R6", 32'(wrRej), 1, "enable flag itself locked");
    wpN = 1; doWren(); doWrite(8'h07);
    wpN = 0; doWren(); doWrite(8'h03);
    chk("R6", 32'(wrAck), 1, "pin ignored with flag clear");
    chk("R10", 32'(lockMode), 0, "no lock");

    // R3: write-enable in the same cycle as a write
    curReq = "R3";
    wrenReq = 1; wrReq = 1; wrData = 8'h13; tick(); clearIn();
    chk("R3", 32'(wrRej), 1, "same-cycle enable not used");
    chk("R3", 32'(status[9]), 1, "latch ends set");
    doWrite(8'h13);
    chk("R3", 32'(wrAck), 1, "later write uses latch");

    // R7: power-lock
    curReq = "R7";
    doWren(); doWrite(8'h93);
    chk("R7", 32'(status[7]), 1, "power-lock set");
    chk("R10", 32'(lockMode), 2, "power mode");
    doWren(); doWrite(8'h11);
    chk("R7", 32'(wrRej), 1, "power-lock blocks change");
    doWren(); doWrite(8'h13);
    chk("R7", 32'(status[7]), 1, "bit 7 low does not clear");
    wpN = 1; doWren(); doWrite(8'h11);
    chk("R7", 32'(wrRej), 1, "blocks with pin high");
    curReq = "R1";
    powerCycle();
    chk("R1", 32'(status), 32'h013, "power cycle keeps non-volatile bits");
    curReq = "R7";
    doWren(); doWrite(8'h11);
    chk("R7", 32'(wrAck), 1, "released after power cycle");

    // R9: sequence aborts
    curReq = "R9";
    doSeq(8'hA5); doSeq(8'h00); doSeq(8'h5A);
    chk("R9", 32'(status[8]), 0, "aborted by other byte");
    doSeq(8'h5A);
    chk("R9", 32'(status[8]), 0, "second byte alone");

    // R11 with R8: code completes on the same edge as a changing write
    curReq = "R11";
    doSeq(8'hA5); doSeq(8'hA5); doWren();
    seqByte = 8'h5A; seqValid = 1; wrData = 8'h15; wrReq = 1; tick(); clearIn();
    chk("R11", 32'(wrAck), 1, "write judged on old lock");
    chk("R11", 32'(status[6:0]), 32'h15, "bits written");
    chk("R8", 32'(status[8]), 1, "permanent lock set");
    chk("R10", 32'(lockMode), 3, "perm mode");
    curReq = "R8";
    doWren(); doWrite(8'h11);
    chk("R8", 32'(wrRej), 1, "perm blocks change");
    powerCycle();
    chk("R8", 32'(status[8]), 1, "perm survives power cycle");
    doWren(); doWrite(8'h95);
    chk("R10", 32'(lockMode), 3, "perm above power-lock");
    curReq = "R1";
    rstN = 0; blankN = 0; tick();
    rstN = 1; blankN = 1; tick();
    chk("R1", 32'(status), 0, "blank clears all");

    curReq = "R9";
    doSeq(8'hA5); doSeq(8'h12); doSeq(8'h5A);
    chk("R9", 32'(status[8]), 0, "abort after blank");

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule